// File: doc/BRIEF.md
# Page ECC Status Evaluator

This block runs once a page read with hardware error correction has filled one of the page buffers. It walks the per-sector error-count fields that belong to that buffer and adds every correctable count to a running total. When a sector reports an uncorrectable result, it scans the buffer to decide whether the page is corrupt or was simply never programmed.

A caller first pulses `arm` to show that the coming read uses hardware correction. When the read finishes, the caller pulses `start` together with the buffer number and the number of sectors per page. The block fetches buffer words through a one-cycle-latency read port. It then pulses `done` and reports the increment for this page, the uncorrectable flag and the updated total. The arm request is consumed at `done`, so a later start without a new arm does not evaluate the status fields again.

Top module: `ecc_page_eval`

## Requirements
- R1: The 4-bit count for sector n is in status word n/4, bits [(3 - n mod 4)*8 +: 4]. The lowest-numbered sector of a word therefore sits in its most significant byte. The upper nibble of each byte is ignored.
- R2: An armed evaluation examines exactly `sectPerPage` consecutive sectors, starting at sector `bufNum * sectPerPage`. `corrInc` is the sum of their counts.
- R3: A count of 15 marks an uncorrectable sector. The walk stops there, so the counts of later sectors are not added to `corrInc`.
- R4: After an uncorrectable sector, `uncorrErr` is 1 when any main-area word of the buffer differs from 0xFFFFFFFF.
- R5: After an uncorrectable sector, `uncorrErr` is 0 when every main-area word and every word of the correction-byte run reads 0xFFFFFFFF.
- R6: The correction-byte run starts 8 bytes into the spare area and spans ECC_BPS bytes per sector. A non-0xFF word inside the run sets `uncorrErr`. A non-0xFF word in the spare area outside the run does not.
- R7: Buffer b starts at word b*2*PAGE_WORDS, and its spare area starts PAGE_WORDS words later. Every read address stays inside the selected buffer.
- R8: At each `done`, `corrTotal` grows by `corrInc`. At all other times it holds its value.
- R9: `done` lasts one cycle. A `start` without a preceding `arm` since the last `done` produces `done` with `corrInc` 0 and `uncorrErr` 0, and issues no read.
- R10: After reset, `done`, `memRd`, `uncorrErr` and `corrTotal` are 0.
- R11: The blank scan stops at the first mismatching word. After that mismatch comes back, no further read is issued, and no read index passes the end of the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Marks the next evaluation as a hardware-corrected read |
| start | input | 1 | Begin evaluation pulse |
| bufNum | input | log2(STAT_WORDS*4) | Buffer that was filled |
| sectPerPage | input | log2(STAT_WORDS*4)+1 | Sectors per page |
| statWords | input | STAT_WORDS*32 | Packed per-sector status words |
| memData | input | 32 | Buffer word, valid one cycle after memRd |
| memRd | output | 1 | Buffer read strobe |
| memAddr | output | log2(STAT_WORDS*8*PAGE_BYTES/4) | Buffer word address |
| corrInc | output | log2(STAT_WORDS*56+1) | Corrected errors found on this page |
| corrTotal | output | CNT_W | Cumulative corrected errors |
| uncorrErr | output | 1 | Uncorrectable, non-blank page |
| done | output | 1 | Evaluation finished pulse |

## Verification
The assertions check on every cycle that `done` is a single pulse and that the total changes only at `done`, by exactly `corrInc`. They also check that every read address lies inside the selected buffer, that no read index passes the end of the scan region, and that no read follows a returned mismatch. Only the bench scenarios can show whether the sums and the blank decision are correct. These scenarios cover the nibble placement, the starting sector for each buffer, the stop at code 15, and which spare-area bytes count toward blankness. Randomized status words and buffer contents are compared against a model computed in the bench.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;
  typedef struct packed {
    logic loadSect;  // latch buffer/sector setup, clear accumulator
    logic addSect;   // add current sector count, advance sector
    logic clrRd;     // reset blank-scan read index
    logic issueRd;   // issue one buffer word read
    logic finish;    // publish results and pulse done
    logic fatal;     // result is an uncorrectable non-blank page
  } evalCtl_t;
endpackage

// File: rtl/ecc_eval_ctrl.sv
module ecc_eval_ctrl
  import ecc_eval_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic       start,
  input  logic [3:0] code,
  input  logic       lastSect,
  input  logic       rdAllIssued,
  input  logic       mismatch,
  input  logic       rdLastOk,
  output evalCtl_t   ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_BLANK} state_t;

  state_t state, stateNxt;
  logic   armed;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (armed) begin
            ctl.loadSect = 1'b1;
            stateNxt     = ST_SCAN;
          end else begin
            ctl.finish = 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (code == 4'hF) begin
          ctl.clrRd = 1'b1;
          stateNxt  = ST_BLANK;
        end else begin
          ctl.addSect = 1'b1;
          if (lastSect) begin
            ctl.finish = 1'b1;
            stateNxt   = ST_IDLE;
          end
        end
      end
      ST_BLANK: begin
        if (mismatch) begin
          ctl.finish = 1'b1;
          ctl.fatal  = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (rdLastOk) begin
          ctl.finish = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (!rdAllIssued) begin
          ctl.issueRd = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNxt;
      if (arm)             armed <= 1'b1;
      else if (ctl.finish) armed <= 1'b0;
    end
  end

  AST_SCAN_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_BLANK) |-> !ctl.issueRd); // R11
endmodule

// File: rtl/ecc_eval_dp.sv
module ecc_eval_dp
  import ecc_eval_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ECC_BPS    = 8,
  parameter int STAT_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  evalCtl_t                          ctl,
  input  logic [$clog2(STAT_WORDS*4)-1:0]   bufNum,
  input  logic [$clog2(STAT_WORDS*4):0]     sectPerPage,
  input  logic [STAT_WORDS*32-1:0]          statWords,
  input  logic [31:0]                       memData,
  output logic [3:0]                        code,
  output logic                              lastSect,
  output logic                              rdAllIssued,
  output logic                              mismatch,
  output logic                              rdLastOk,
  output logic [$clog2(STAT_WORDS*8*PAGE_BYTES/4)-1:0] memAddr,
  output logic [$clog2(STAT_WORDS*56+1)-1:0] corrInc,
  output logic [CNT_W-1:0]                  corrTotal,
  output logic                              uncorrErr,
  output logic                              done
);
  localparam int MAX_SECT   = STAT_WORDS * 4;
  localparam int SECT_W     = $clog2(MAX_SECT);
  localparam int BIT_W      = $clog2(STAT_WORDS * 32);
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int ECC_WPS    = ECC_BPS / 4;
  localparam int ADDR_W     = $clog2(MAX_SECT * 2 * PAGE_WORDS);
  localparam int INC_W      = $clog2(MAX_SECT * 14 + 1);
  localparam int RD_W       = $clog2(PAGE_WORDS + MAX_SECT * ECC_WPS + 3);
  localparam logic [ADDR_W-1:0] BUF_STRIDE = ADDR_W'(2 * PAGE_WORDS);

  logic [SECT_W-1:0] sectIdx, bufQ;
  logic [SECT_W:0]   sectEnd, sppQ;
  logic [INC_W-1:0]  acc, accSum;
  logic [RD_W-1:0]   rdIdx, totalWords;
  logic              rdValid, rdLast;
  logic [ADDR_W-1:0] base;
  logic [BIT_W-1:0]  bitOfs;

  // sector n: word n/4, byte 3 - n%4, low nibble
  assign bitOfs   = {sectIdx[SECT_W-1:2], ~sectIdx[1:0], 3'b000};
  assign code     = statWords[bitOfs +: 4];
  assign lastSect = ({1'b0, sectIdx} == sectEnd);
  assign accSum   = acc + (ctl.addSect ? INC_W'(code) : INC_W'(0));

  assign base        = ADDR_W'(bufQ) * BUF_STRIDE;
  assign totalWords  = RD_W'(PAGE_WORDS) + RD_W'(sppQ) * RD_W'(ECC_WPS);
  assign rdAllIssued = (rdIdx == totalWords);
  assign memAddr     = base + ((rdIdx < RD_W'(PAGE_WORDS)) ? ADDR_W'(rdIdx)
                                                         : ADDR_W'(rdIdx + RD_W'(2)));
  assign mismatch    = rdValid && (memData != 32'hFFFF_FFFF);
  assign rdLastOk    = rdValid && rdLast && (memData == 32'hFFFF_FFFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectIdx   <= '0;
      sectEnd   <= '0;
      bufQ      <= '0;
      sppQ      <= '0;
      acc       <= '0;
      rdIdx     <= '0;
      rdValid   <= 1'b0;
      rdLast    <= 1'b0;
      corrInc   <= '0;
      corrTotal <= '0;
      uncorrErr <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.loadSect) begin
        bufQ    <= bufNum;
        sppQ    <= sectPerPage;
        sectIdx <= SECT_W'(bufNum * sectPerPage);
        sectEnd <= (SECT_W+1)'(bufNum * sectPerPage) + sectPerPage - (SECT_W+1)'(1);
        acc     <= '0;
      end else if (ctl.addSect) begin
        sectIdx <= sectIdx + SECT_W'(1);
        acc     <= accSum;
      end
      if (ctl.clrRd) begin
        rdIdx   <= '0;
        rdValid <= 1'b0;
        rdLast  <= 1'b0;
      end else begin
        rdValid <= ctl.issueRd;
        rdLast  <= ctl.issueRd && (rdIdx == totalWords - RD_W'(1));
        if (ctl.issueRd) rdIdx <= rdIdx + RD_W'(1);
      end
      if (ctl.finish) begin
        corrInc   <= accSum;
        uncorrErr <= ctl.fatal;
        corrTotal <= corrTotal + CNT_W'(accSum);
        acc       <= '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> corrTotal == $past(corrTotal) + CNT_W'(corrInc)); // R8
  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(corrTotal)); // R8
  AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueRd |-> (ADDR_W'(memAddr - base) < BUF_STRIDE)); // R7
  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueRd |-> rdIdx < totalWords); // R11
  AST_STOP_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> !ctl.issueRd); // R11
endmodule

// File: rtl/ecc_page_eval.sv
module ecc_page_eval
  import ecc_eval_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ECC_BPS    = 8,
  parameter int STAT_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        arm,
  input  logic                                        start,
  input  logic [$clog2(STAT_WORDS*4)-1:0]             bufNum,
  input  logic [$clog2(STAT_WORDS*4):0]               sectPerPage,
  input  logic [STAT_WORDS*32-1:0]                    statWords,
  input  logic [31:0]                                 memData,
  output logic                                        memRd,
  output logic [$clog2(STAT_WORDS*8*PAGE_BYTES/4)-1:0] memAddr,
  output logic [$clog2(STAT_WORDS*56+1)-1:0]          corrInc,
  output logic [CNT_W-1:0]                            corrTotal,
  output logic                                        uncorrErr,
  output logic                                        done
);
  evalCtl_t   ctl;
  logic [3:0] code;
  logic       lastSect, rdAllIssued, mismatch, rdLastOk;

  assign memRd = ctl.issueRd;

  ecc_eval_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .arm(arm), .start(start), .code(code),
    .lastSect(lastSect), .rdAllIssued(rdAllIssued), .mismatch(mismatch),
    .rdLastOk(rdLastOk), .ctl(ctl)
  );

  ecc_eval_dp #(
    .PAGE_BYTES(PAGE_BYTES), .ECC_BPS(ECC_BPS),
    .STAT_WORDS(STAT_WORDS), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bufNum(bufNum),
    .sectPerPage(sectPerPage), .statWords(statWords), .memData(memData),
    .code(code), .lastSect(lastSect), .rdAllIssued(rdAllIssued),
    .mismatch(mismatch), .rdLastOk(rdLastOk), .memAddr(memAddr),
    .corrInc(corrInc), .corrTotal(corrTotal), .uncorrErr(uncorrErr),
    .done(done)
  );
endmodule

// File: tb/ecc_page_eval_tb_top.sv
`timescale 1ns/1ps
module ecc_page_eval_tb_top;
  localparam int PB = 128, PW = PB / 4, EBPS = 8, SW = 4, NSECT = SW * 4;

  logic        clk = 1'b0, rstN = 1'b0, arm = 1'b0, start = 1'b0;
  logic [3:0]  bufNum = '0;
  logic [4:0]  sectPerPage = 5'd1;
  logic [127:0] statWords = '0;
  logic [31:0] memData;
  logic        memRd, uncorrErr, done;
  logic [9:0]  memAddr;
  logic [7:0]  corrInc;
  logic [31:0] corrTotal;

  logic [31:0] mem [0:1023];
  int rdCnt = 0;
  int nChecks = 0, nFails = 0;
  int expTotal = 0;
  int gotInc, gotErr, gotReads;

  always #2 clk = ~clk;

  ecc_page_eval #(.PAGE_BYTES(PB), .ECC_BPS(EBPS), .STAT_WORDS(SW), .CNT_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .arm(arm), .start(start), .bufNum(bufNum),
    .sectPerPage(sectPerPage), .statWords(statWords), .memData(memData),
    .memRd(memRd), .memAddr(memAddr), .corrInc(corrInc), .corrTotal(corrTotal),
    .uncorrErr(uncorrErr), .done(done)
  );

  always @(posedge clk) begin
    if (memRd) begin
      memData <= mem[memAddr];
      rdCnt   <= rdCnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCode(input int s, input int c, input int hi);
    statWords[(s / 4) * 32 + (3 - s % 4) * 8 +: 8] = {4'(hi), 4'(c)};
  endtask

  function automatic int getCode(input int s);
    return int'(statWords[(s / 4) * 32 + (3 - s % 4) * 8 +: 4]);
  endfunction

  task automatic blankBuf(input int b);
    for (int w = 0; w < 2 * PW; w++) mem[b * 2 * PW + w] = 32'hFFFF_FFFF;
  endtask

  function automatic bit isBlank(input int b, input int spp);
    for (int w = 0; w < PW; w++)
      if (mem[b * 2 * PW + w] != 32'hFFFF_FFFF) return 1'b0;
    for (int e = 0; e < spp * EBPS / 4; e++)
      if (mem[b * 2 * PW + PW + 2 + e] != 32'hFFFF_FFFF) return 1'b0;
    return 1'b1;
  endfunction

  task automatic expect_(input int b, input int spp, output int eInc, output int eErr);
    eInc = 0; eErr = 0;
    for (int s = b * spp; s < b * spp + spp; s++) begin
      if (getCode(s) == 15) begin
        eErr = isBlank(b, spp) ? 0 : 1;
        break;
      end
      eInc += getCode(s);
    end
  endtask

  task automatic runOp(input bit doArm, input int b, input int spp);
    int r0, cyc;
    @(negedge clk);
    bufNum = 4'(b); sectPerPage = 5'(spp); arm = doArm;
    @(negedge clk);
    arm = 1'b0; start = 1'b1; r0 = rdCnt;
    @(negedge clk);
    start = 1'b0; cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    chk("R9 done seen", int'(done), 1);
    gotInc = int'(corrInc); gotErr = int'(uncorrErr); gotReads = rdCnt - r0;
    if (doArm) begin
      expTotal += gotInc;
      chk("R8 total", int'(corrTotal), expTotal);
    end
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic runChecked(input int b, input int spp, input string tag);
    int eInc, eErr;
    expect_(b, spp, eInc, eErr);
    runOp(1'b1, b, spp);
    chk({tag, " inc"}, gotInc, eInc);
    chk({tag, " err"}, gotErr, eErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 done", int'(done), 0);
    chk("R10 memRd", int'(memRd), 0);
    chk("R10 uncorrErr", int'(uncorrErr), 0);
    chk("R10 corrTotal", int'(corrTotal), 0);
    rstN = 1'b1;

    // R1: nibble placement with junk upper nibbles
    for (int s = 0; s < NSECT; s++) setCode(s, 0, 4'hA);
    setCode(0, 1, 4'hF); setCode(1, 2, 4'h7); setCode(2, 3, 4'h5); setCode(3, 4, 4'hE);
    runOp(1'b1, 0, 4);
    chk("R1 nibble sum", gotInc, 10);
    chk("R1 no error", gotErr, 0);

    // R2: buffer 2 with 4 sectors -> sectors 8..11 only
    for (int s = 0; s < NSECT; s++) setCode(s, 9, 0);
    setCode(8, 1, 0); setCode(9, 0, 0); setCode(10, 5, 0); setCode(11, 2, 0);
    runOp(1'b1, 2, 4);
    chk("R2 buffer 2 sum", gotInc, 8);
    runOp(1'b1, 3, 2);
    chk("R2 buffer 3 of 2 sectors", gotInc, 18);

    // R3 + R5: fatal at sector 1, page blank
    for (int s = 0; s < NSECT; s++) setCode(s, 3, 0);
    setCode(1, 15, 0);
    blankBuf(0);
    runOp(1'b1, 0, 4);
    chk("R3 stop at fatal", gotInc, 3);
    chk("R5 blank excused", gotErr, 0);
    chk("R5 full scan reads", gotReads, PW + 4 * EBPS / 4);

    // R4 + R11: main word 5 non-blank
    mem[5] = 32'hFFFF_FFFE;
    runOp(1'b1, 0, 4);
    chk("R4 main not blank", gotErr, 1);
    chk("R11 stop early", int'(gotReads <= 7), 1);
    blankBuf(0);

    // R6: ECC run word vs spare words outside run
    mem[PW + 2 + 7] = 32'h00FF_FFFF;
    runOp(1'b1, 0, 4);
    chk("R6 ecc byte dirty", gotErr, 1);
    blankBuf(0);
    mem[PW] = 32'h0; mem[PW + 1] = 32'h1234_5678; mem[PW + 2 + 8] = 32'h0;
    runOp(1'b1, 0, 4);
    chk("R6 non-ecc spare ignored", gotErr, 0);
    blankBuf(0);

    // R7: buffer 1 blank-check uses its own area
    setCode(4, 15, 0);
    blankBuf(1);
    mem[0] = 32'h0;
    runOp(1'b1, 1, 4);
    chk("R7 other buffer ignored", gotErr, 0);
    mem[2 * PW + 3] = 32'h0;
    runOp(1'b1, 1, 4);
    chk("R7 own buffer main", gotErr, 1);
    blankBuf(0); blankBuf(1);

    // R9: start without arm
    setCode(0, 2, 0);
    runOp(1'b0, 0, 4);
    chk("R9 unarmed inc", gotInc, 0);
    chk("R9 unarmed err", gotErr, 0);
    chk("R9 unarmed reads", gotReads, 0);
    chk("R9 unarmed total", int'(corrTotal), expTotal);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int spp, b, pick, r;
      spp = 1 << ($urandom % 3);
      b = $urandom % (NSECT / spp);
      for (int s = 0; s < NSECT; s++) begin
        r = $urandom % 20;
        setCode(s, (r >= 17) ? 15 : r % 15, $urandom % 16);
      end
      blankBuf(b);
      pick = $urandom % 4;
      if (pick == 1) mem[b * 2 * PW + ($urandom % PW)] = ~(32'd1 << ($urandom % 32));
      if (pick == 2) mem[b * 2 * PW + PW + 2 + ($urandom % (spp * 2))] = 32'h0;
      if (pick == 3) mem[b * 2 * PW + PW + ($urandom % 2)] = 32'h0;
      runChecked(b, spp, "R2 R3 R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule